// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and a single processor core. Each cycle the distributor offers its best pending candidate as an identifier and a priority, where a numerically smaller priority value is more urgent. The block raises the interrupt request line when four conditions all hold: the software enable is set, the candidate is more urgent than the programmed priority threshold, the candidate is allowed to preempt whatever the core is already servicing, and the line is not inside its short blanking window after an acknowledge.

An acknowledge from the core returns the candidate identifier, or the spurious code when nothing qualifies. A successful acknowledge also pulses an activation notice back to the distributor and pushes the candidate's priority onto a small stack of running priorities. An end-of-interrupt carrying the identifier of the innermost active interrupt pops that stack, which restores the previous running priority, and it pulses a deactivation notice to the distributor. An end-of-interrupt with any other identifier leaves all state alone and raises a sticky error flag.

Top module: `cpu_irq_ack_if`

## Requirements
- R1: After synchronous active-low reset, `irq_out`, `ack_valid`, `act_valid`, `deact_valid` and `eoi_err` are 0, and `run_prio` is 8'hFF, the idle value.
- R2: A candidate qualifies when `cfg_enable` is 1, `cand_valid` is 1, `cand_prio` < `cfg_prio_mask`, preemption allows it, and no blanking is in progress. `irq_out` is the value of this qualification registered one cycle later, and it is forced to 0 when `ack_req` was high in the same cycle.
- R3: While `cfg_enable` is 0, or while `cand_prio` >= `cfg_prio_mask`, `irq_out` stays 0 and an acknowledge returns the spurious identifier.
- R4: When no interrupt is active, any candidate passes the preemption check. When at least one interrupt is active, a candidate passes only if `cfg_preempt_en` is 1 and `cand_prio` is strictly below `run_prio`. Equal priority never preempts.
- R5: An `ack_req` cycle always produces `ack_valid` in the next cycle. If the candidate qualified, `ack_id` and `act_id` equal `cand_id`, `act_valid` pulses, and `run_prio` becomes `cand_prio`.
- R6: An acknowledge with no qualifying candidate returns `ack_id` = 1023 (all ones), gives no `act_valid`, and changes neither `run_prio` nor the active stack.
- R7: After a successful acknowledge, `irq_out` is 0 in the following cycle, and qualification is suppressed for BLANK_CYC (default 2) further cycles. An acknowledge during that window is spurious.
- R8: An end-of-interrupt whose `eoi_id` equals the innermost active identifier pulses `deact_valid` with `deact_id` = `eoi_id` in the next cycle, pops the stack, and restores `run_prio` to the previous entry, or to 8'hFF when the stack becomes empty.
- R9: An end-of-interrupt on an empty stack, or one whose identifier does not match the innermost active identifier, produces no `deact_valid` and leaves `run_prio` unchanged. It sets `eoi_err`, which then stays 1 until reset.
- R10: The stack holds STACK_DEPTH (default 4) active interrupts. While it is full, no candidate qualifies, so `irq_out` stays 0 and an acknowledge is spurious.
- R11: When an acknowledge and an end-of-interrupt fall in the same cycle, the end-of-interrupt is matched against the stack as it stood before that cycle, and the acknowledge is qualified against the pre-cycle `run_prio` and fullness. A matching pop is applied first and a successful push second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Software enable for signalling to the core |
| cfg_prio_mask | input | 8 | Priority threshold; only priorities numerically below it pass |
| cfg_preempt_en | input | 1 | Allows nesting of a more urgent interrupt over an active one |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt identifier |
| cand_prio | input | 8 | Candidate priority, lower value is more urgent |
| ack_req | input | 1 | Acknowledge read strobe from the core |
| ack_valid | output | 1 | Acknowledge response valid, one cycle after `ack_req` |
| ack_id | output | 10 | Acknowledged identifier or 1023 for spurious |
| act_valid | output | 1 | Pulse telling the distributor to mark `act_id` active |
| act_id | output | 10 | Identifier being activated |
| eoi_req | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | Identifier carried by the end-of-interrupt |
| deact_valid | output | 1 | Pulse telling the distributor to mark `deact_id` inactive |
| deact_id | output | 10 | Identifier being deactivated |
| irq_out | output | 1 | Interrupt request line to the core |
| run_prio | output | 8 | Priority of the innermost active interrupt, 8'hFF when idle |
| eoi_err | output | 1 | Sticky flag for a mismatched or unexpected end-of-interrupt |

## Verification
The acknowledge and the end-of-interrupt can land in the same cycle, and the result then depends on which stack state each one sees. The bench drives both strobes together in two directed cases. In the first, the candidate beats the old running priority, so the completion pops and the new entry is pushed in its place. In the second, the candidate sits between the old and the restored running priority, so the acknowledge must come back spurious while the pop still happens. A long random phase then issues both strobes freely, often with the true innermost identifier. A behavioural model built on queues judges every output on every cycle.

// File: rtl/cpu_irq_pkg.sv
// Package: shared widths, constants and the active-stack entry type for the
// per-CPU interrupt acknowledge interface.
// Assumes: priority values compare numerically, smaller meaning more urgent.
package cpu_irq_pkg;

    localparam int ID_W        = 10;
    localparam int PRIO_W      = 8;
    localparam int SPURIOUS_ID = (1 << ID_W) - 1;

    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } act_entry_t;

endpackage

// File: rtl/cpu_irq_run_stack.sv
// Module: cpu_irq_run_stack
// Holds the nested active interrupts (identifier and priority) as a LIFO.
// A pop and a push in one cycle replace the top entry.
// Assumes: the caller never pushes while full unless it pops in the same
// cycle, and never pops while empty.
module cpu_irq_run_stack
    import cpu_irq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  act_entry_t push_entry,
    output act_entry_t top_entry,
    output logic       empty,
    output logic       full
);

    localparam int CW = $clog2(DEPTH + 1);

    act_entry_t    slot_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] wr_idx;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CW'(DEPTH));
    assign wr_idx = pop ? (cnt_q - CW'(1)) : cnt_q;

    // Occupancy count: up on push, down on pop, unchanged on both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !pop) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (pop && !push) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Slot storage: the pushed entry lands at the write index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == CW'(i)) begin
                    slot_q[i] <= push_entry;
                end
            end
        end
    end

    // Top select: the newest entry, or zero when empty.
    always_comb begin
        top_entry = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CW'(i + 1)) begin
                top_entry = slot_q[i];
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);  // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R8

endmodule

// File: rtl/cpu_irq_gate.sv
// Module: cpu_irq_gate
// Decides whether the offered candidate qualifies (enable, threshold,
// preemption, blanking) and drives the registered request line. It also
// owns the blanking counter that starts after each successful acknowledge.
// Assumes: run_prio is the idle value whenever stk_empty is set.
module cpu_irq_gate
    import cpu_irq_pkg::*;
#(
    parameter int BLANK_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [PRIO_W-1:0] cfg_prio_mask,
    input  logic              cfg_preempt_en,
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              stk_empty,
    input  logic              stk_full,
    input  logic              ack_req,
    output logic              qualify,
    output logic              irq_out
);

    localparam int BW = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);

    logic [BW-1:0] blank_q;
    logic          pass_mask;
    logic          preempt_ok;
    logic          irq_q;

    // Qualification: threshold, nesting policy and blanking window.
    always_comb begin
        pass_mask  = (cand_prio < cfg_prio_mask);
        preempt_ok = stk_empty ||
                     (!stk_full && cfg_preempt_en && (cand_prio < run_prio));
        qualify    = cfg_enable && cand_valid && pass_mask && preempt_ok &&
                     (blank_q == '0);
    end

    // Blanking counter: loaded on a taken acknowledge, then counts down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_q <= '0;
        end else if (ack_req && qualify) begin
            blank_q <= BW'(BLANK_CYC);
        end else if (blank_q != '0) begin
            blank_q <= blank_q - BW'(1);
        end
    end

    // Request line: registered qualification, dropped by an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= qualify && !ack_req;
        end
    end

    assign irq_out = irq_q;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(cfg_enable));  // R3
    AST_IRQ_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(cand_prio < cfg_prio_mask));  // R3
    AST_IRQ_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && qualify) |=> !irq_out);  // R7
    AST_NO_IRQ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |=> !irq_out);  // R10

endmodule

// File: rtl/cpu_irq_handshake.sv
// Module: cpu_irq_handshake
// Turns acknowledge and end-of-interrupt strobes into stack operations,
// registered responses to the core and notices to the distributor, and
// keeps the sticky completion error flag.
// Assumes: top_id is meaningful only when stk_empty is clear.
module cpu_irq_handshake
    import cpu_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_req,
    input  logic              qualify,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              eoi_req,
    input  logic [ID_W-1:0]   eoi_id,
    input  logic [ID_W-1:0]   top_id,
    input  logic              stk_empty,
    output logic              stk_push,
    output logic              stk_pop,
    output act_entry_t        push_entry,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_id,
    output logic              act_valid,
    output logic [ID_W-1:0]   act_id,
    output logic              deact_valid,
    output logic [ID_W-1:0]   deact_id,
    output logic              eoi_err
);

    logic eoi_match;

    // Stack controls: pop on a matching completion, push on a taken acknowledge.
    always_comb begin
        eoi_match       = eoi_req && !stk_empty && (eoi_id == top_id);
        stk_pop         = eoi_match;
        stk_push        = ack_req && qualify;
        push_entry.id   = cand_id;
        push_entry.prio = cand_prio;
    end

    // Acknowledge response and activation notice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_id    <= '0;
            act_valid <= 1'b0;
            act_id    <= '0;
        end else begin
            ack_valid <= ack_req;
            ack_id    <= !ack_req ? '0 : (qualify ? cand_id : ID_W'(SPURIOUS_ID));
            act_valid <= ack_req && qualify;
            act_id    <= (ack_req && qualify) ? cand_id : '0;
        end
    end

    // Deactivation notice and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deact_valid <= 1'b0;
            deact_id    <= '0;
            eoi_err     <= 1'b0;
        end else begin
            deact_valid <= eoi_match;
            deact_id    <= eoi_match ? eoi_id : '0;
            if (eoi_req && !eoi_match) begin
                eoi_err <= 1'b1;
            end
        end
    end

    AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);  // R5
    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && (ack_id == ID_W'(SPURIOUS_ID))) |-> !act_valid);  // R6
    AST_DEACT_FROM_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        deact_valid |-> ($past(eoi_req) && (deact_id == $past(eoi_id))));  // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_err |=> eoi_err);  // R9

endmodule

// File: rtl/cpu_irq_ack_if.sv
// Module: cpu_irq_ack_if (top)
// Per-CPU interrupt acknowledge interface. Gates the distributor's best
// candidate by enable, priority threshold and nesting policy, drives the
// request line, answers acknowledge and end-of-interrupt strobes, and keeps
// a stack of running priorities.
// Assumes: the distributor never offers identifier 1023; activation and
// deactivation notices are consumed by the distributor within BLANK_CYC.
module cpu_irq_ack_if
    import cpu_irq_pkg::*;
#(
    parameter int STACK_DEPTH = 4,
    parameter int BLANK_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [PRIO_W-1:0] cfg_prio_mask,
    input  logic              cfg_preempt_en,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              ack_req,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_id,
    output logic              act_valid,
    output logic [ID_W-1:0]   act_id,
    input  logic              eoi_req,
    input  logic [ID_W-1:0]   eoi_id,
    output logic              deact_valid,
    output logic [ID_W-1:0]   deact_id,
    output logic              irq_out,
    output logic [PRIO_W-1:0] run_prio,
    output logic              eoi_err
);

    act_entry_t top_entry;
    act_entry_t push_entry;
    logic       stk_empty;
    logic       stk_full;
    logic       stk_push;
    logic       stk_pop;
    logic       qualify;

    // Running priority: innermost active priority, idle value when none.
    assign run_prio = stk_empty ? IDLE_PRIO : top_entry.prio;

    cpu_irq_run_stack #(
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (stk_push),
        .pop        (stk_pop),
        .push_entry (push_entry),
        .top_entry  (top_entry),
        .empty      (stk_empty),
        .full       (stk_full)
    );

    cpu_irq_gate #(
        .BLANK_CYC (BLANK_CYC)
    ) u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_enable     (cfg_enable),
        .cfg_prio_mask  (cfg_prio_mask),
        .cfg_preempt_en (cfg_preempt_en),
        .cand_valid     (cand_valid),
        .cand_prio      (cand_prio),
        .run_prio       (run_prio),
        .stk_empty      (stk_empty),
        .stk_full       (stk_full),
        .ack_req        (ack_req),
        .qualify        (qualify),
        .irq_out        (irq_out)
    );

    cpu_irq_handshake u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_req     (ack_req),
        .qualify     (qualify),
        .cand_id     (cand_id),
        .cand_prio   (cand_prio),
        .eoi_req     (eoi_req),
        .eoi_id      (eoi_id),
        .top_id      (top_entry.id),
        .stk_empty   (stk_empty),
        .stk_push    (stk_push),
        .stk_pop     (stk_pop),
        .push_entry  (push_entry),
        .ack_valid   (ack_valid),
        .ack_id      (ack_id),
        .act_valid   (act_valid),
        .act_id      (act_id),
        .deact_valid (deact_valid),
        .deact_id    (deact_id),
        .eoi_err     (eoi_err)
    );

    AST_ACT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> $past(ack_req));  // R5
    AST_ACT_RAISES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && !deact_valid) |-> (run_prio != IDLE_PRIO || $past(cand_prio) == IDLE_PRIO));  // R5
    AST_RUN_STABLE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eoi_req) && !deact_valid && !act_valid) |-> $stable(run_prio));  // R9

endmodule

// File: tb/cpu_irq_ack_if_tb.sv
// Bench for cpu_irq_ack_if: directed scenarios plus a random phase, with a
// behavioural queue model compared against every output on every cycle.
module cpu_irq_ack_if_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int BLANK      = 2;
    localparam int SPUR       = 1023;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en, pre, cv, ack, eoi;
    logic [7:0] mask, cp;
    logic [9:0] cid, eid;

    logic       ack_valid, act_valid, deact_valid, irq_out, eoi_err;
    logic [9:0] ack_id, act_id, deact_id;
    logic [7:0] run_prio;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // model state
    int q_id[$];
    int q_pr[$];
    int m_blank;
    int e_irq, e_ackv, e_ackid, e_act, e_actid, e_deact, e_deactid, e_err, e_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_irq_ack_if #(.STACK_DEPTH(DEPTH), .BLANK_CYC(BLANK)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(en), .cfg_prio_mask(mask), .cfg_preempt_en(pre),
        .cand_valid(cv), .cand_id(cid), .cand_prio(cp),
        .ack_req(ack), .ack_valid(ack_valid), .ack_id(ack_id),
        .act_valid(act_valid), .act_id(act_id),
        .eoi_req(eoi), .eoi_id(eid),
        .deact_valid(deact_valid), .deact_id(deact_id),
        .irq_out(irq_out), .run_prio(run_prio), .eoi_err(eoi_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act_v, input int exp_v);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act_v, exp_v);
        end
    endtask

    // One clock of the reference model, using the inputs now applied.
    task automatic model_step();
        int  run;
        bit  full, pok, qual, match;
        if (!rst_n) begin
            q_id.delete(); q_pr.delete();
            m_blank = 0;
            e_irq = 0; e_ackv = 0; e_ackid = 0; e_act = 0; e_actid = 0;
            e_deact = 0; e_deactid = 0; e_err = 0; e_run = 255;
            return;
        end
        run   = (q_id.size() == 0) ? 255 : q_pr[$];
        full  = (q_id.size() == DEPTH);
        pok   = (q_id.size() == 0) || (!full && pre && (int'(cp) < run));
        qual  = en && cv && (cp < mask) && pok && (m_blank == 0);
        match = eoi && (q_id.size() > 0) && (int'(eid) == q_id[$]);
        e_irq     = qual && !ack;
        e_ackv    = ack;
        e_ackid   = ack ? (qual ? int'(cid) : SPUR) : 0;
        e_act     = ack && qual;
        e_actid   = e_act ? int'(cid) : 0;
        e_deact   = match;
        e_deactid = match ? int'(eid) : 0;
        if (eoi && !match) e_err = 1;
        if (match) begin
            void'(q_id.pop_back());
            void'(q_pr.pop_back());
        end
        if (ack && qual) begin
            q_id.push_back(int'(cid));
            q_pr.push_back(int'(cp));
            m_blank = BLANK;
        end else if (m_blank > 0) begin
            m_blank--;
        end
        e_run = (q_id.size() == 0) ? 255 : q_pr[$];
    endtask

    task automatic compare_all();
        chk(irq_out == e_irq[0],        "R2",  "irq_out",     irq_out,     e_irq);
        chk(ack_valid == e_ackv[0],     "R5",  "ack_valid",   ack_valid,   e_ackv);
        chk(int'(ack_id) == e_ackid,    "R6",  "ack_id",      ack_id,      e_ackid);
        chk(act_valid == e_act[0],      "R5",  "act_valid",   act_valid,   e_act);
        chk(int'(act_id) == e_actid,    "R5",  "act_id",      act_id,      e_actid);
        chk(deact_valid == e_deact[0],  "R8",  "deact_valid", deact_valid, e_deact);
        chk(int'(deact_id) == e_deactid,"R8",  "deact_id",    deact_id,    e_deactid);
        chk(eoi_err == e_err[0],        "R9",  "eoi_err",     eoi_err,     e_err);
        chk(int'(run_prio) == e_run,    "R11", "run_prio",    run_prio,    e_run);
    endtask

    // Apply current inputs for one edge, then compare at the falling edge.
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input int n);
        ack = 0; eoi = 0;
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic offer(input int id, input int pr);
        cv = 1; cid = 10'(id); cp = 8'(pr);
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic do_eoi(input int id);
        eoi = 1; eid = 10'(id); tick(); eoi = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("[TB] watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 0; en = 1; pre = 1; mask = 8'hF0; cv = 0; cid = 0; cp = 8'hFF;
        ack = 0; eoi = 0; eid = 0;
        @(negedge clk);
        tick(); tick(); tick();
        rst_n = 1;

        // R1: reset state
        chk(irq_out == 0 && ack_valid == 0 && act_valid == 0 && deact_valid == 0,
            "R1", "outputs idle", irq_out, 0);
        chk(eoi_err == 0, "R1", "eoi_err", eoi_err, 0);
        chk(run_prio == 8'hFF, "R1", "run_prio", run_prio, 255);

        // R2: qualifying candidate raises the line one cycle later
        offer(40, 8'h80);
        tick();
        chk(irq_out == 1, "R2", "irq on qualify", irq_out, 1);

        // R3: enable low drops the line, acknowledge spurious
        en = 0; tick();
        chk(irq_out == 0, "R3", "irq with enable low", irq_out, 0);
        do_ack();
        chk(ack_id == 10'(SPUR), "R3", "ack while disabled", ack_id, SPUR);
        en = 1; mask = 8'h80; idle(2);
        chk(irq_out == 0, "R3", "irq at prio equal mask", irq_out, 0);
        mask = 8'hF0; tick();

        // R5: successful acknowledge
        do_ack();
        chk(ack_valid == 1 && ack_id == 10'd40, "R5", "ack_id", ack_id, 40);
        chk(act_valid == 1 && act_id == 10'd40, "R5", "act_id", act_id, 40);
        chk(run_prio == 8'h80, "R5", "run_prio after ack", run_prio, 128);

        // R7: blanking, acknowledge inside window is spurious
        offer(50, 8'h40);
        do_ack();
        chk(irq_out == 0, "R7", "irq after ack", irq_out, 0);
        chk(ack_id == 10'(SPUR) && act_valid == 0, "R7", "ack in blank", ack_id, SPUR);
        chk(run_prio == 8'h80, "R6", "run_prio kept on spurious", run_prio, 128);
        idle(2);
        chk(irq_out == 1, "R4", "preempting irq", irq_out, 1);

        // R4: preemption policy
        pre = 0; idle(2);
        chk(irq_out == 0, "R4", "preempt disabled", irq_out, 0);
        pre = 1; offer(55, 8'h80); idle(2);
        chk(irq_out == 0, "R4", "equal prio no preempt", irq_out, 0);
        offer(50, 8'h40); idle(1);

        // fill the stack to depth 4
        do_ack();
        chk(act_id == 10'd50 && run_prio == 8'h40, "R5", "nested ack", act_id, 50);
        offer(60, 8'h30); idle(3); do_ack();
        offer(70, 8'h20); idle(3); do_ack();
        chk(run_prio == 8'h20, "R5", "run_prio depth 4", run_prio, 32);

        // R10: full stack blocks
        offer(80, 8'h10); idle(3);
        chk(irq_out == 0, "R10", "irq when full", irq_out, 0);
        do_ack();
        chk(ack_id == 10'(SPUR) && act_valid == 0, "R10", "ack when full", ack_id, SPUR);

        // R9: mismatched completion
        cv = 0;
        do_eoi(60);
        chk(deact_valid == 0, "R9", "no deact on mismatch", deact_valid, 0);
        chk(eoi_err == 1, "R9", "err set", eoi_err, 1);
        chk(run_prio == 8'h20, "R9", "run_prio unchanged", run_prio, 32);

        // R8: matching completion
        do_eoi(70);
        chk(deact_valid == 1 && deact_id == 10'd70, "R8", "deact id", deact_id, 70);
        chk(run_prio == 8'h30, "R8", "run_prio restored", run_prio, 48);
        chk(eoi_err == 1, "R9", "err sticky", eoi_err, 1);

        // R11: ack and completion together, candidate beats old running prio
        offer(90, 8'h28); idle(1);
        ack = 1; eoi = 1; eid = 10'd60; tick(); ack = 0; eoi = 0;
        chk(act_valid == 1 && act_id == 10'd90, "R11", "act with eoi", act_id, 90);
        chk(deact_valid == 1 && deact_id == 10'd60, "R11", "deact with ack", deact_id, 60);
        chk(run_prio == 8'h28, "R11", "top replaced", run_prio, 40);

        // R11: candidate between old and restored running prio -> spurious
        offer(95, 8'h38); idle(3);
        ack = 1; eoi = 1; eid = 10'd90; tick(); ack = 0; eoi = 0;
        chk(ack_id == 10'(SPUR) && act_valid == 0, "R11", "ack judged pre-eoi", ack_id, SPUR);
        chk(deact_id == 10'd90, "R11", "pop still done", deact_id, 90);
        chk(run_prio == 8'h40, "R11", "run after pop", run_prio, 64);

        // drain
        cv = 0;
        do_eoi(50);
        do_eoi(40);
        chk(run_prio == 8'hFF, "R8", "idle after drain", run_prio, 255);
        do_eoi(40);
        chk(deact_valid == 0, "R9", "eoi on empty", deact_valid, 0);

        // random phase with periodic reset
        for (int n = 0; n < 6000; n++) begin
            rst_n = !((n % 700) == 699);
            en    = ($urandom % 10) != 0;
            pre   = ($urandom % 6) != 0;
            mask  = (($urandom % 4) == 0) ? 8'($urandom) : 8'hF0;
            cv    = ($urandom % 4) != 0;
            cid   = 10'($urandom % 1023);
            cp    = 8'($urandom);
            ack   = ($urandom % 5) == 0;
            eoi   = ($urandom % 6) == 0;
            if (q_id.size() > 0 && ($urandom % 4) != 0) eid = 10'(q_id[$]);
            else eid = 10'($urandom % 1023);
            tick();
        end
        rst_n = 1;
        idle(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule